// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Unit

This block sits beside the decode-to-execute boundary of an in-order five-stage pipeline. It looks at the two source registers of the instruction about to execute. It compares them with the destinations of the two older instructions still in flight. One of those older instructions is in the execute-to-memory latch and the other is in the memory-to-writeback latch. From that comparison it decides, for each source, whether the register-file value is stale. A stale value is either replaced with a newer result or, failing that, causes a stall of the younger instruction.

The unit is purely combinational. A two-bit configuration input selects one of three behaviours:

- **Pass-through:** no hazard handling at all.
- **Stall-only:** stall whenever any hazard exists.
- **Bypass:** forward results wherever possible and stall only when a load in the execute-to-memory latch feeds the waiting instruction.

The mode is treated as static configuration. For each operand the unit returns the value to use and a two-bit code saying where that value came from.

Top module: `raw_bypass_unit`

## Requirements
- R1: A hazard against an older stage exists only when that stage's write enable is 1, its destination index is nonzero, the source is flagged as used, and the two indices are equal; register 0 never causes forwarding or a stall.
- R2: Mode 2'b00 and the unused mode 2'b11 perform no hazard handling: `stall_o` is 0, both source codes are 2'b00 and both operands equal their register-file inputs.
- R3: Mode 2'b01 (stall-only) raises `stall_o` exactly when a hazard exists against either older stage; operands keep their register-file values and codes stay 2'b00.
- R4: In mode 2'b10 (bypass), an operand with a hazard only against the writeback latch takes `wbk_val_i` and code 2'b10.
- R5: In mode 2'b10, an operand with a hazard against the execute-to-memory latch, when that latch is not a load, takes `exm_alu_i` and code 2'b01.
- R6: In mode 2'b10, a hazard against an execute-to-memory latch that is a load raises `stall_o`. That operand is not taken from `exm_alu_i`: it takes the writeback value (code 2'b10) if it also has a writeback hazard, else its register-file value (code 2'b00).
- R7: In mode 2'b10, when one operand matches both older stages and the execute-to-memory latch is not a load, the newer result `exm_alu_i` wins with code 2'b01.
- R8: In mode 2'b10, `stall_o` is raised only by the load-use case of R6; writeback hazards and non-load execute-to-memory hazards never stall.
- R9: An operand with no applicable forwarding keeps its register-file value with code 2'b00; code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | 00/11 pass-through, 01 stall-only, 10 bypass |
| src1_idx_i | input | REG_AW | Index of first source register |
| src1_used_i | input | 1 | First source is read by the instruction |
| src1_rf_i | input | XLEN | Register-file read of first source |
| src2_idx_i | input | REG_AW | Index of second source register |
| src2_used_i | input | 1 | Second source is read by the instruction |
| src2_rf_i | input | XLEN | Register-file read of second source |
| exm_rd_i | input | REG_AW | Destination index in execute-to-memory latch |
| exm_wen_i | input | 1 | Execute-to-memory instruction writes a register |
| exm_load_i | input | 1 | Execute-to-memory instruction reads memory |
| exm_alu_i | input | XLEN | ALU result held in execute-to-memory latch |
| wbk_rd_i | input | REG_AW | Destination index in writeback latch |
| wbk_wen_i | input | 1 | Writeback instruction writes a register |
| wbk_val_i | input | XLEN | Value being written back |
| op1_o | output | XLEN | Resolved first operand |
| op2_o | output | XLEN | Resolved second operand |
| fwd1_o | output | 2 | Source of op1: 00 register file, 01 execute-to-memory, 10 writeback |
| fwd2_o | output | 2 | Source of op2, same encoding |
| stall_o | output | 1 | Hold the decode-stage instruction for a cycle |

## Verification
The sweep drives every mix of indices 0, 1 and 2 through both sources and both older destinations. It covers every write-enable, use-flag and load setting in all four mode codes. This exposes a unit that forwards from register 0, which would corrupt operands with the garbage a discarded x0 write carries. It also exposes one that ignores the use flags and stalls needlessly, or one that lets the writeback value override the newer execute result and so executes on stale data. The load-use corner with a simultaneous writeback match is checked separately. A unit that forwarded the load's address instead of stalling, or that dropped the writeback bypass while stalled, would show a wrong operand or a missing stall there.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_STALL  = 2'b01,
        MODE_BYPASS = 2'b10
    } hz_mode_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_MEM = 2'b01,
        SRC_WB  = 2'b10
    } fwd_src_e;

    localparam int NUM_OPS = 2;
endpackage

// File: rtl/rbu_match.sv
module rbu_match #(
    parameter int REG_AW  = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [REG_AW-1:0]         rd_i,
    input  logic                      wen_i,
    input  logic [NUM_OPS*REG_AW-1:0] src_idx_i,
    input  logic [NUM_OPS-1:0]        src_used_i,
    output logic [NUM_OPS-1:0]        hit_o
);
    logic writes_real;
    assign writes_real = wen_i && (rd_i != '0);

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
        assign hit_o[g] = writes_real && src_used_i[g]
                       && (src_idx_i[g*REG_AW +: REG_AW] == rd_i);
    end
endmodule

// File: rtl/rbu_select.sv
module rbu_select
    import rbu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      mode_i,
    input  logic            hit_m_i,
    input  logic            hit_w_i,
    input  logic            exm_load_i,
    input  logic [XLEN-1:0] rf_i,
    input  logic [XLEN-1:0] exm_i,
    input  logic [XLEN-1:0] wbk_i,
    output logic [XLEN-1:0] val_o,
    output logic [1:0]      code_o
);
    fwd_src_e sel;

    always_comb begin
        sel = SRC_RF;
        if (mode_i == MODE_BYPASS) begin
            if (hit_w_i)               sel = SRC_WB;
            if (hit_m_i && !exm_load_i) sel = SRC_MEM;
        end
    end

    always_comb begin
        case (sel)
            SRC_MEM: val_o = exm_i;
            SRC_WB:  val_o = wbk_i;
            default: val_o = rf_i;
        endcase
    end

    assign code_o = sel;
endmodule

// File: rtl/raw_bypass_unit.sv
module raw_bypass_unit
    import rbu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [1:0]        mode_i,
    input  logic [REG_AW-1:0] src1_idx_i,
    input  logic              src1_used_i,
    input  logic [XLEN-1:0]   src1_rf_i,
    input  logic [REG_AW-1:0] src2_idx_i,
    input  logic              src2_used_i,
    input  logic [XLEN-1:0]   src2_rf_i,
    input  logic [REG_AW-1:0] exm_rd_i,
    input  logic              exm_wen_i,
    input  logic              exm_load_i,
    input  logic [XLEN-1:0]   exm_alu_i,
    input  logic [REG_AW-1:0] wbk_rd_i,
    input  logic              wbk_wen_i,
    input  logic [XLEN-1:0]   wbk_val_i,
    output logic [XLEN-1:0]   op1_o,
    output logic [XLEN-1:0]   op2_o,
    output logic [1:0]        fwd1_o,
    output logic [1:0]        fwd2_o,
    output logic              stall_o
);
    localparam int IDXW = NUM_OPS * REG_AW;

    logic [IDXW-1:0]         src_idx;
    logic [NUM_OPS-1:0]      src_used;
    logic [NUM_OPS-1:0]      hit_m;
    logic [NUM_OPS-1:0]      hit_w;
    logic [XLEN-1:0]         rf_val  [NUM_OPS];
    logic [XLEN-1:0]         res_val [NUM_OPS];
    logic [1:0]              res_code[NUM_OPS];

    assign src_idx   = {src2_idx_i, src1_idx_i};
    assign src_used  = {src2_used_i, src1_used_i};
    assign rf_val[0] = src1_rf_i;
    assign rf_val[1] = src2_rf_i;

    rbu_match #(.REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) u_match_mem (
        .rd_i       (exm_rd_i),
        .wen_i      (exm_wen_i),
        .src_idx_i  (src_idx),
        .src_used_i (src_used),
        .hit_o      (hit_m)
    );

    rbu_match #(.REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) u_match_wb (
        .rd_i       (wbk_rd_i),
        .wen_i      (wbk_wen_i),
        .src_idx_i  (src_idx),
        .src_used_i (src_used),
        .hit_o      (hit_w)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        rbu_select #(.XLEN(XLEN)) u_sel (
            .mode_i     (mode_i),
            .hit_m_i    (hit_m[g]),
            .hit_w_i    (hit_w[g]),
            .exm_load_i (exm_load_i),
            .rf_i       (rf_val[g]),
            .exm_i      (exm_alu_i),
            .wbk_i      (wbk_val_i),
            .val_o      (res_val[g]),
            .code_o     (res_code[g])
        );
    end

    always_comb begin
        case (mode_i)
            MODE_STALL:  stall_o = (|hit_m) || (|hit_w);
            MODE_BYPASS: stall_o = (|hit_m) && exm_load_i;
            default:     stall_o = 1'b0;
        endcase
    end

    assign op1_o  = res_val[0];
    assign op2_o  = res_val[1];
    assign fwd1_o = res_code[0];
    assign fwd2_o = res_code[1];
endmodule

// File: rtl/raw_bypass_unit_chk.sv
module raw_bypass_unit_chk #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input logic [1:0]        mode_i,
    input logic [REG_AW-1:0] src1_idx_i,
    input logic              src1_used_i,
    input logic [XLEN-1:0]   src1_rf_i,
    input logic [REG_AW-1:0] src2_idx_i,
    input logic              src2_used_i,
    input logic [XLEN-1:0]   src2_rf_i,
    input logic [REG_AW-1:0] exm_rd_i,
    input logic              exm_wen_i,
    input logic              exm_load_i,
    input logic [XLEN-1:0]   exm_alu_i,
    input logic [REG_AW-1:0] wbk_rd_i,
    input logic              wbk_wen_i,
    input logic [XLEN-1:0]   wbk_val_i,
    input logic [XLEN-1:0]   op1_o,
    input logic [XLEN-1:0]   op2_o,
    input logic [1:0]        fwd1_o,
    input logic [1:0]        fwd2_o,
    input logic              stall_o
);
    logic known;
    assign known = !$isunknown({mode_i, src1_idx_i, src1_used_i, src2_idx_i, src2_used_i,
                                exm_rd_i, exm_wen_i, exm_load_i, wbk_rd_i, wbk_wen_i,
                                fwd1_o, fwd2_o, stall_o});

    always_comb begin
        if (known) begin
            p_off_quiet_r2: assert (!((mode_i == 2'b00 || mode_i == 2'b11)
                                      && (stall_o || fwd1_o != 2'b00 || fwd2_o != 2'b00)))
                else $error("pass-through mode produced activity");
            p_stall_only_pass_r3: assert (!(mode_i == 2'b01
                                      && (fwd1_o != 2'b00 || fwd2_o != 2'b00
                                          || op1_o != src1_rf_i || op2_o != src2_rf_i)))
                else $error("stall-only mode altered an operand");
            p_code_legal_r9: assert (fwd1_o != 2'b11 && fwd2_o != 2'b11)
                else $error("illegal source code");
            p_wb_value_r4: assert (!((fwd1_o == 2'b10 && op1_o != wbk_val_i)
                                     || (fwd2_o == 2'b10 && op2_o != wbk_val_i)))
                else $error("writeback code without writeback value");
            p_mem_value_r5: assert (!((fwd1_o == 2'b01 && op1_o != exm_alu_i)
                                      || (fwd2_o == 2'b01 && op2_o != exm_alu_i)))
                else $error("memory-stage code without its value");
            p_x0_inert_r1: assert (!(exm_rd_i == '0 && wbk_rd_i == '0
                                     && (stall_o || fwd1_o != 2'b00 || fwd2_o != 2'b00)))
                else $error("register 0 caused a hazard");
            p_loaduse_only_r8: assert (!(mode_i == 2'b10 && stall_o && !exm_load_i))
                else $error("bypass mode stalled without a load");
        end
    end
endmodule

bind raw_bypass_unit raw_bypass_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (.*);

// File: tb/raw_bypass_unit_bench.sv
module raw_bypass_unit_bench;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam logic [XLEN-1:0] V_RF1 = 32'h1111_0001;
    localparam logic [XLEN-1:0] V_RF2 = 32'h2222_0002;
    localparam logic [XLEN-1:0] V_EXM = 32'hAAAA_000A;
    localparam logic [XLEN-1:0] V_WBK = 32'hBBBB_000B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]        mode;
    logic [REG_AW-1:0] s1, s2, mrd, wrd;
    logic              u1, u2, mwen, mload, wwen;
    logic [XLEN-1:0]   op1, op2;
    logic [1:0]        f1, f2;
    logic              stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    raw_bypass_unit #(.XLEN(XLEN), .REG_AW(REG_AW)) u_raw_bypass_unit (
        .mode_i(mode), .src1_idx_i(s1), .src1_used_i(u1), .src1_rf_i(V_RF1),
        .src2_idx_i(s2), .src2_used_i(u2), .src2_rf_i(V_RF2),
        .exm_rd_i(mrd), .exm_wen_i(mwen), .exm_load_i(mload), .exm_alu_i(V_EXM),
        .wbk_rd_i(wrd), .wbk_wen_i(wwen), .wbk_val_i(V_WBK),
        .op1_o(op1), .op2_o(op2), .fwd1_o(f1), .fwd2_o(f2), .stall_o(stall)
    );

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h (mode=%0d s1=%0d/%0d s2=%0d/%0d m=%0d/%0d/%0d w=%0d/%0d)",
                     tag, what, act, exp, mode, s1, u1, s2, u2, mrd, mwen, mload, wrd, wwen);
        end
    endtask

    task automatic apply(input logic [1:0] md, input int a1, input bit b1, input int a2, input bit b2,
                         input int m, input bit mw, input bit ml, input int w, input bit ww);
        @(posedge clk);
        mode = md; s1 = REG_AW'(a1); u1 = b1; s2 = REG_AW'(a2); u2 = b2;
        mrd = REG_AW'(m); mwen = mw; mload = ml; wrd = REG_AW'(w); wwen = ww;
        @(negedge clk);
    endtask

    // Reference from the requirements, for one operand.
    task automatic expect_op(input logic [1:0] md, input int src, input bit used,
                             input logic [XLEN-1:0] rf, output logic [XLEN-1:0] v,
                             output logic [1:0] c, output string tag);
        bit hm, hw;
        hm = mwen && (mrd != 0) && used && (src == int'(mrd));
        hw = wwen && (wrd != 0) && used && (src == int'(wrd));
        v = rf; c = 2'b00;
        if (md == 2'b00 || md == 2'b11) tag = "R2";
        else if (md == 2'b01) tag = "R3";
        else if (hm && !mload && hw) begin v = V_EXM; c = 2'b01; tag = "R7"; end
        else if (hm && !mload)       begin v = V_EXM; c = 2'b01; tag = "R5"; end
        else if (hm && mload && hw)  begin v = V_WBK; c = 2'b10; tag = "R6"; end
        else if (hm && mload)        tag = "R6";
        else if (hw)                 begin v = V_WBK; c = 2'b10; tag = "R4"; end
        else                         tag = "R9";
        if (!(mwen && mrd == 0) && !(wwen && wrd == 0)) begin end
    endtask

    task automatic check_all();
        logic [XLEN-1:0] ev1, ev2;
        logic [1:0] ec1, ec2;
        string t1, t2, ts;
        bit hm, hwa, es;
        expect_op(mode, int'(s1), u1, V_RF1, ev1, ec1, t1);
        expect_op(mode, int'(s2), u2, V_RF2, ev2, ec2, t2);
        hm  = mwen && (mrd != 0) && ((u1 && s1 == mrd) || (u2 && s2 == mrd));
        hwa = wwen && (wrd != 0) && ((u1 && s1 == wrd) || (u2 && s2 == wrd));
        case (mode)
            2'b01:   begin es = hm || hwa;   ts = "R3"; end
            2'b10:   begin es = hm && mload; ts = (hm && mload) ? "R6" : "R8"; end
            default: begin es = 1'b0;        ts = "R2"; end
        endcase
        chk(t1, "op1",   op1, ev1);
        chk(t1, "fwd1",  XLEN'(f1), XLEN'(ec1));
        chk(t2, "op2",   op2, ev2);
        chk(t2, "fwd2",  XLEN'(f2), XLEN'(ec2));
        chk(ts, "stall", XLEN'(stall), XLEN'(es));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        mode = 2'b00; s1 = '0; s2 = '0; u1 = 0; u2 = 0;
        mrd = '0; mwen = 0; mload = 0; wrd = '0; wwen = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state after reset: everything passes through (R9)
        chk("R9", "idle stall", XLEN'(stall), '0);
        chk("R9", "idle op1", op1, V_RF1);
        chk("R9", "idle fwd1", XLEN'(f1), '0);

        // R1 directed: register 0 destination never hazards
        apply(2'b10, 0, 1, 0, 1, 0, 1, 0, 0, 1);
        chk("R1", "x0 fwd1", XLEN'(f1), '0);
        chk("R1", "x0 op1", op1, V_RF1);
        apply(2'b01, 0, 1, 0, 1, 0, 1, 1, 0, 1);
        chk("R1", "x0 stall", XLEN'(stall), '0);
        // R1: unused source matching a destination
        apply(2'b01, 3, 0, 3, 0, 3, 1, 0, 3, 1);
        chk("R1", "unused stall", XLEN'(stall), '0);
        // R1: write enable low
        apply(2'b10, 4, 1, 4, 1, 4, 0, 0, 4, 0);
        chk("R1", "no wen fwd2", XLEN'(f2), '0);
        chk("R1", "no wen op2", op2, V_RF2);
        // R6 directed: load in MEM plus writeback match on same operand
        apply(2'b10, 5, 1, 0, 0, 5, 1, 1, 5, 1);
        chk("R6", "loaduse stall", XLEN'(stall), 1);
        chk("R6", "loaduse op1", op1, V_WBK);
        chk("R6", "loaduse fwd1", XLEN'(f1), 2);

        // Near-exhaustive sweep over indices 0..2
        for (int md = 0; md < 4; md++)
        for (int a1 = 0; a1 < 3; a1++)
        for (int a2 = 0; a2 < 3; a2++)
        for (int uu = 0; uu < 4; uu++)
        for (int m = 0; m < 3; m++)
        for (int mf = 0; mf < 4; mf++)
        for (int w = 0; w < 3; w++)
        for (int ww = 0; ww < 2; ww++) begin
            apply(md[1:0], a1, uu[0], a2, uu[1], m, mf[0], mf[1], w, ww[0]);
            check_all();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule